// File: doc/BRIEF.md
# Clocked Bridge to an Asynchronous Static RAM

This block lets a clocked host read and write a 16-bit-wide asynchronous static RAM that has no clock pin of its own. The host offers one transfer at a time through a request strobe, a direction flag, a word address, write data and a per-byte enable. The bridge then drives the memory's chip selects, write strobe, output enable and per-byte lane controls in a fixed sequence of phases. Each phase length is a clock count derived by ceiling division from nanosecond minima, so the same block meets the memory's timing at any clock period.

The memory's shared data bus is modelled as three plain signals: a driven value, a drive enable and a sampled input. The bridge drives the bus only while the write strobe is low. It never lets output enable and write strobe be active together. After every read it holds the memory deselected for a turnaround interval, so the memory has let go of the bus before the next transfer can start. The host sees `ready` while the bridge is idle and a one-clock `done` at the end of each transfer. Read data is registered on that same edge.

Top module: `sram_async_bridge`

## Requirements
- R1: After reset and whenever `ready` is high, the memory is deselected: `mem_cs1_n`=1, `mem_cs2`=0, `mem_bc_n`=2'b11, `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0. During reset `done` is 0 and `ready` goes high.
- R2: A write whose byte enable is nonzero asserts both chip selects for one setup clock with `mem_we_n` high. It then holds `mem_we_n` low for exactly 6 clocks (ceil(max(55 ns, 60 ns − setup)/10 ns)) and drives `mem_dq_out` (`mem_dq_oe`=1) only during those clocks.
- R3: A write lasts 8 clocks from acceptance to `done`, which is at least the 70 ns cycle time. `mem_addr` stays stable for as long as the chip selects stay asserted. After a write's `done`, `ready` is already high.
- R4: A read with nonzero byte enable holds `mem_oe_n` low and `mem_we_n` high for 7 clocks (ceil(70 ns/10 ns)). `done` rises 7 clocks after acceptance, and on that same edge `rdata` holds the memory bus sampled at the end of the access.
- R5: Byte enable bit 0 maps to `mem_bc_n[0]` and data bits 7:0, and bit 1 maps to `mem_bc_n[1]` and bits 15:8. A disabled lane is neither written in the memory nor returned: it reads as zero in `rdata`.
- R6: A transfer with byte enable 2'b00 completes with `done` on the clock edge that accepts it. No chip select or strobe is asserted, memory contents are unchanged, and `rdata` keeps its previous value.
- R7: `done` is high for one clock per transfer. A request raised while `ready` is low is ignored and starts no transfer.
- R8: After each read the memory stays deselected for 3 clocks (ceil(25 ns/10 ns)) before `ready` returns. The bus drive enable is never raised within 3 clocks of `mem_oe_n` rising.
- R9: `mem_oe_n` and `mem_we_n` are never low together, and `mem_dq_oe` is never high while `mem_oe_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Transfer request, sampled while `ready` is high |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 18 | Word address |
| wdata | input | 16 | Write data |
| be | input | 2 | Byte enable, bit 0 = bits 7:0 |
| ready | output | 1 | Bridge idle, request may be raised |
| done | output | 1 | One-clock end-of-transfer pulse |
| rdata | output | 16 | Registered read data |
| mem_addr | output | 18 | Memory address bus |
| mem_cs1_n | output | 1 | Chip select, active low |
| mem_cs2 | output | 1 | Chip select, active high |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_bc_n | output | 2 | Byte lane controls, active low, bit 0 = lower byte |
| mem_dq_out | output | 16 | Value driven onto the data bus |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | 16 | Value sampled from the data bus |

## Verification
A phase counter that is wrong by one shows at once as a write strobe or read access one clock too short or too long. It also moves `done`, which the bench times to the clock against the required counts on every transfer. A lane decode that is wrong shows on the next read of that address, as a byte missing, stale or not zeroed in `rdata`. A sequencer that leaves its idle state wrongly shows within a clock as an asserted chip select while `ready` is high, or as a missing turnaround before `ready` returns.

// File: rtl/sram_bridge_pkg.sv
// Shared types and constant helpers for the asynchronous SRAM bridge.
// Assumes: all timing values are non-negative integers in nanoseconds.
package sram_bridge_pkg;

    // Sequencer phases; each phase fixes the memory pin levels.
    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_WSETUP  = 3'd1,
        PH_WSTROBE = 3'd2,
        PH_WHOLD   = 3'd3,
        PH_RACCESS = 3'd4,
        PH_RTURN   = 3'd5
    } phase_t;

    // Ceiling conversion of a nanosecond minimum into clock cycles.
    function automatic int ns_to_cyc(input int ns, input int period_ns);
        return (ns + period_ns - 1) / period_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // True for phases in which the chip is selected.
    function automatic logic phase_selects(input phase_t ph);
        return (ph == PH_WSETUP) || (ph == PH_WSTROBE) ||
               (ph == PH_WHOLD)  || (ph == PH_RACCESS);
    endfunction

endpackage

// File: rtl/sram_seq.sv
// Phase sequencer for the SRAM bridge. One transfer at a time; every
// phase length is a cycle-count parameter (>= 1). Exposes both the
// current and next phase so pin drivers can register their outputs.
// Assumes: be_any is only meaningful when req is high in idle.
module sram_seq
    import sram_bridge_pkg::*;
#(
    parameter int SETUP_CYC  = 1,
    parameter int PULSE_CYC  = 6,
    parameter int HOLD_CYC   = 1,
    parameter int ACCESS_CYC = 7,
    parameter int TURN_CYC   = 3
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req,
    input  logic   wr,
    input  logic   be_any,
    output phase_t phase_q,
    output phase_t phase_d,
    output logic   accept,
    output logic   capture,
    output logic   ready,
    output logic   done
);
    localparam int MAX_CYC = imax(imax(SETUP_CYC, PULSE_CYC),
                                  imax(imax(HOLD_CYC, ACCESS_CYC), TURN_CYC));
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    localparam logic [CNT_W-1:0] SETUP_LD  = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] PULSE_LD  = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LD   = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] ACCESS_LD = CNT_W'(ACCESS_CYC - 1);
    localparam logic [CNT_W-1:0] TURN_LD   = CNT_W'(TURN_CYC - 1);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             done_d;
    logic             expired;

    assign expired = (cnt_q == '0);
    assign ready   = (phase_q == PH_IDLE);
    assign accept  = ready && req;

    // Next phase, counter reload and end-of-transfer decision.
    always_comb begin
        phase_d = phase_q;
        cnt_d   = expired ? cnt_q : cnt_q - 1'b1;
        done_d  = 1'b0;
        capture = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                if (accept) begin
                    if (!be_any) begin
                        done_d = 1'b1;
                    end else if (wr) begin
                        phase_d = PH_WSETUP;
                        cnt_d   = SETUP_LD;
                    end else begin
                        phase_d = PH_RACCESS;
                        cnt_d   = ACCESS_LD;
                    end
                end
            end
            PH_WSETUP: begin
                if (expired) begin
                    phase_d = PH_WSTROBE;
                    cnt_d   = PULSE_LD;
                end
            end
            PH_WSTROBE: begin
                if (expired) begin
                    phase_d = PH_WHOLD;
                    cnt_d   = HOLD_LD;
                end
            end
            PH_WHOLD: begin
                if (expired) begin
                    phase_d = PH_IDLE;
                    done_d  = 1'b1;
                end
            end
            PH_RACCESS: begin
                if (expired) begin
                    phase_d = PH_RTURN;
                    cnt_d   = TURN_LD;
                    capture = 1'b1;
                    done_d  = 1'b1;
                end
            end
            PH_RTURN: begin
                if (expired) begin
                    phase_d = PH_IDLE;
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // State, counter and done pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            done    <= 1'b0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
            done    <= done_d;
        end
    end

endmodule

// File: rtl/sram_pins.sv
// Registered control-pin driver: decodes the sequencer's next phase so
// every memory strobe comes straight from a flop, aligned with the phase.
// Assumes: phase_d is the value the phase register loads on this edge.
module sram_pins
    import sram_bridge_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  phase_t phase_d,
    output logic   cs1_n,
    output logic   cs2,
    output logic   we_n,
    output logic   oe_n,
    output logic   dq_oe
);
    logic sel_nxt;
    assign sel_nxt = phase_selects(phase_d);

    // Chip selects, strobes and bus drive, deselected in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs1_n <= 1'b1;
            cs2   <= 1'b0;
            we_n  <= 1'b1;
            oe_n  <= 1'b1;
            dq_oe <= 1'b0;
        end else begin
            cs1_n <= !sel_nxt;
            cs2   <= sel_nxt;
            we_n  <= !(phase_d == PH_WSTROBE);
            oe_n  <= !(phase_d == PH_RACCESS);
            dq_oe <= (phase_d == PH_WSTROBE);
        end
    end

endmodule

// File: rtl/sram_lane.sv
// One byte lane: drives its active-low lane control from the next phase
// and captures its slice of the read bus, zeroing a disabled lane.
// Assumes: en_nxt is the lane enable valid for the next phase.
module sram_lane #(
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_nxt,
    input  logic              en_nxt,
    input  logic              en_q,
    input  logic              capture,
    input  logic [LANE_W-1:0] dq_in,
    output logic              bc_n,
    output logic [LANE_W-1:0] rd_byte
);
    // Lane control register, inactive in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) bc_n <= 1'b1;
        else        bc_n <= !(sel_nxt && en_nxt);
    end

    // Read capture at the end of the access window.
    always_ff @(posedge clk) begin
        if (!rst_n)       rd_byte <= '0;
        else if (capture) rd_byte <= en_q ? dq_in : '0;
    end

endmodule

// File: rtl/sram_async_bridge.sv
// Top of the clocked-host to asynchronous-SRAM bridge. Converts the
// nanosecond minima to clock counts, latches each accepted request and
// ties sequencer, pin driver and byte lanes together.
// Assumes: host raises req only while ready is high, holding fields that
// cycle; the memory bus is split into out/enable/in signals.
module sram_async_bridge
    import sram_bridge_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int LANE_W     = 8,
    parameter int LANES      = 2,
    parameter int CLK_NS     = 10,
    parameter int T_RC_NS    = 70,
    parameter int T_WC_NS    = 70,
    parameter int T_AA_NS    = 70,
    parameter int T_OE_NS    = 35,
    parameter int T_WP_NS    = 55,
    parameter int T_AW_NS    = 60,
    parameter int T_AS_NS    = 0,
    parameter int T_HZ_NS    = 25
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req,
    input  logic                    wr,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [LANES-1:0]        be,
    output logic                    ready,
    output logic                    done,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic                    mem_cs1_n,
    output logic                    mem_cs2,
    output logic                    mem_we_n,
    output logic                    mem_oe_n,
    output logic [LANES-1:0]        mem_bc_n,
    output logic [LANES*LANE_W-1:0] mem_dq_out,
    output logic                    mem_dq_oe,
    input  logic [LANES*LANE_W-1:0] mem_dq_in
);
    localparam int DATA_W     = LANES * LANE_W;
    localparam int SETUP_CYC  = imax(1, ns_to_cyc(T_AS_NS, CLK_NS));
    localparam int PULSE_CYC  = imax(ns_to_cyc(T_WP_NS, CLK_NS),
                                     ns_to_cyc(T_AW_NS, CLK_NS) - SETUP_CYC);
    localparam int HOLD_CYC   = imax(1, ns_to_cyc(T_WC_NS, CLK_NS) - SETUP_CYC - PULSE_CYC);
    localparam int ACCESS_CYC = imax(ns_to_cyc(T_RC_NS, CLK_NS),
                                     imax(ns_to_cyc(T_AA_NS, CLK_NS),
                                          ns_to_cyc(T_OE_NS, CLK_NS)));
    localparam int TURN_CYC   = imax(1, ns_to_cyc(T_HZ_NS, CLK_NS));

    phase_t              phase_q, phase_d;
    logic                accept, capture;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   wdata_q;
    logic [LANES-1:0]    be_q, be_nxt;
    logic                sel_nxt;

    assign be_nxt  = accept ? be : be_q;
    assign sel_nxt = phase_selects(phase_d);

    sram_seq #(
        .SETUP_CYC (SETUP_CYC),
        .PULSE_CYC (PULSE_CYC),
        .HOLD_CYC  (HOLD_CYC),
        .ACCESS_CYC(ACCESS_CYC),
        .TURN_CYC  (TURN_CYC)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (req),
        .wr     (wr),
        .be_any (|be),
        .phase_q(phase_q),
        .phase_d(phase_d),
        .accept (accept),
        .capture(capture),
        .ready  (ready),
        .done   (done)
    );

    sram_pins u_pins (
        .clk    (clk),
        .rst_n  (rst_n),
        .phase_d(phase_d),
        .cs1_n  (mem_cs1_n),
        .cs2    (mem_cs2),
        .we_n   (mem_we_n),
        .oe_n   (mem_oe_n),
        .dq_oe  (mem_dq_oe)
    );

    // Request latch: address, data and lane enables held for the transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
        end else if (accept && (|be)) begin
            addr_q  <= addr;
            wdata_q <= wdata;
            be_q    <= be;
        end
    end

    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        sram_lane #(.LANE_W(LANE_W)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .sel_nxt(sel_nxt),
            .en_nxt (be_nxt[l]),
            .en_q   (be_q[l]),
            .capture(capture),
            .dq_in  (mem_dq_in[l*LANE_W +: LANE_W]),
            .bc_n   (mem_bc_n[l]),
            .rd_byte(rdata[l*LANE_W +: LANE_W])
        );
    end

endmodule

// File: rtl/sram_bridge_chk.sv
// Protocol checker bound to the bridge top: pin exclusivity, idle
// deselection, strobe width, turnaround and address stability.
// Assumes: PULSE_MIN and TURN_MIN match the bridge's derived counts.
module sram_bridge_chk #(
    parameter int ADDR_W    = 18,
    parameter int LANES     = 2,
    parameter int PULSE_MIN = 6,
    parameter int TURN_MIN  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ready,
    input logic              done,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs1_n,
    input logic              mem_cs2,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic [LANES-1:0]  mem_bc_n,
    input logic              mem_dq_oe
);
    logic [7:0] we_run;
    logic [7:0] oe_gap;

    // Length of the current write-strobe low run.
    always_ff @(posedge clk) begin
        if (!rst_n)        we_run <= '0;
        else if (!mem_we_n) we_run <= we_run + 8'd1;
        else               we_run <= '0;
    end

    // Clocks since output enable was last low, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)          oe_gap <= 8'hFF;
        else if (!mem_oe_n)  oe_gap <= '0;
        else if (oe_gap != 8'hFF) oe_gap <= oe_gap + 8'd1;
    end

    p_idle_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (mem_cs1_n && !mem_cs2 && (&mem_bc_n) && mem_we_n && mem_oe_n && !mem_dq_oe));

    p_drive_in_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_we_n && !mem_cs1_n && mem_cs2));

    p_strobe_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_run >= 8'(PULSE_MIN)));

    p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs1_n && $past(!mem_cs1_n)) |-> $stable(mem_addr));

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ready) |=> !done);

    p_turnaround_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (oe_gap > 8'(TURN_MIN)));

    p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_we_n && !mem_oe_n));

    p_no_contention_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_dq_oe && !mem_oe_n));

endmodule

bind sram_async_bridge sram_bridge_chk #(
    .ADDR_W   (ADDR_W),
    .LANES    (LANES),
    .PULSE_MIN(PULSE_CYC),
    .TURN_MIN (TURN_CYC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ready    (ready),
    .done     (done),
    .mem_addr (mem_addr),
    .mem_cs1_n(mem_cs1_n),
    .mem_cs2  (mem_cs2),
    .mem_we_n (mem_we_n),
    .mem_oe_n (mem_oe_n),
    .mem_bc_n (mem_bc_n),
    .mem_dq_oe(mem_dq_oe)
);

// File: tb/tb_sram_async_bridge.sv
// Bench: sweeps every byte-enable value over 16 addresses for writes and
// reads against a small behavioural memory, timing each phase at the pins.
module tb_sram_async_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        wr = 1'b0;
    logic [17:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [1:0]  be = '0;
    logic        ready, done;
    logic [15:0] rdata;
    logic [17:0] mem_addr;
    logic        mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [1:0]  mem_bc_n;
    logic [15:0] mem_dq_out, mem_dq_in;

    int checks = 0;
    int fails  = 0;
    logic [15:0] arr [16];
    logic [15:0] shadow [16];
    int we_run, we_max, sel_seen;

    always #5 clk = ~clk;

    sram_async_bridge dut (
        .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr),
        .wdata(wdata), .be(be), .ready(ready), .done(done), .rdata(rdata),
        .mem_addr(mem_addr), .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_bc_n(mem_bc_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // Behavioural memory: a lane is written when selected under a low strobe.
    always @(posedge clk) begin
        for (int l = 0; l < 2; l++)
            if (!mem_cs1_n && mem_cs2 && !mem_we_n && !mem_bc_n[l] && mem_dq_oe)
                arr[mem_addr[3:0]][l*8 +: 8] <= mem_dq_out[l*8 +: 8];
    end

    // Read bus: unselected lanes carry a junk pattern.
    always_comb begin
        for (int l = 0; l < 2; l++)
            mem_dq_in[l*8 +: 8] = (!mem_cs1_n && mem_cs2 && !mem_oe_n && mem_we_n && !mem_bc_n[l])
                                  ? arr[mem_addr[3:0]][l*8 +: 8] : 8'hA5;
    end

    // Pin monitor: strobe run length and any chip selection.
    always @(negedge clk) begin
        if (!mem_we_n) we_run++; else we_run = 0;
        if (we_run > we_max) we_max = we_run;
        if (!mem_cs1_n || mem_cs2 || !mem_we_n || !mem_oe_n) sel_seen = 1;
    end

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // One transfer; returns clocks to done and clocks from done to ready.
    task automatic xfer(input logic w, input logic [17:0] a, input logic [15:0] d,
                        input logic [1:0] b, output int lat, output int turn);
        while (!ready) @(negedge clk);
        we_max = 0; sel_seen = 0;
        req = 1'b1; wr = w; addr = a; wdata = d; be = b;
        @(posedge clk);
        @(negedge clk);
        req = 1'b0;
        lat = 0;
        while (!done && lat < 100) begin
            @(posedge clk); lat++;
            @(negedge clk);
        end
        turn = 0;
        while (!ready && turn < 100) begin
            @(posedge clk); turn++;
            @(negedge clk);
        end
    endtask

    function automatic logic [15:0] pat(input int a, input int b);
        return {4'(a), 4'(b) ^ 4'hA, ~4'(a), 4'(b + 3)};
    endfunction

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int lat, turn;
        logic [15:0] prev, expd;
        for (int i = 0; i < 16; i++) begin arr[i] = 16'h0; shadow[i] = 16'h0; end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(ready && !done, "R1 ready/done in reset", {ready, done}, 2'b10);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_cs1_n && !mem_cs2 && mem_bc_n == 2'b11 && mem_we_n && mem_oe_n && !mem_dq_oe,
            "R1 pins deselected", {mem_cs1_n, mem_cs2, mem_bc_n, mem_we_n, mem_oe_n, mem_dq_oe}, 7'b1011110);
        chk(rdata == 16'h0, "R1 rdata after reset", rdata, 0);

        // Write sweep: R2, R3, R5, R6
        for (int b = 3; b >= 0; b--) begin
            for (int a = 0; a < 16; a++) begin
                int bb;
                bb = (b == 3) ? 3 : (b == 2) ? 1 : (b == 1) ? 2 : 0;
                xfer(1'b1, 18'(a) | 18'h2A000, pat(a, bb), 2'(bb), lat, turn);
                if (bb[0]) shadow[a][7:0]  = pat(a, bb) >> 0;
                if (bb[1]) shadow[a][15:8] = pat(a, bb) >> 8;
                if (bb == 0) begin
                    chk(lat == 0, "R6 write no-op done at once", lat, 0);
                    chk(sel_seen == 0, "R6 no strobe on no-op", sel_seen, 0);
                end else begin
                    chk(lat == 8, "R3 write length", lat, 8);
                    chk(we_max == 6, "R2 strobe width", we_max, 6);
                    chk(turn == 0, "R3 ready after write", turn, 0);
                end
            end
        end
        for (int a = 0; a < 16; a++)
            chk(arr[a] == shadow[a], "R5 lane write contents", arr[a], shadow[a]);

        // Read sweep: R4, R5, R6, R8
        prev = rdata;
        for (int b = 0; b < 4; b++) begin
            for (int a = 0; a < 16; a++) begin
                xfer(1'b0, 18'(a), 16'h0, 2'(b), lat, turn);
                if (b == 0) begin
                    chk(lat == 0, "R6 read no-op done at once", lat, 0);
                    chk(rdata == prev, "R6 rdata kept on no-op", rdata, prev);
                    chk(sel_seen == 0, "R6 no select on no-op", sel_seen, 0);
                end else begin
                    expd = {b[1] ? shadow[a][15:8] : 8'h00, b[0] ? shadow[a][7:0] : 8'h00};
                    chk(lat == 7, "R4 read access length", lat, 7);
                    chk(rdata == expd, "R4 R5 read data", rdata, expd);
                    chk(turn == 3, "R8 turnaround length", turn, 3);
                end
                prev = rdata;
            end
        end

        // R7: request while busy is ignored; done pulses once
        while (!ready) @(negedge clk);
        req = 1'b1; wr = 1'b1; addr = 18'h3; wdata = 16'hBEEF; be = 2'b11;
        @(posedge clk); @(negedge clk);
        addr = 18'h5; wdata = 16'h1234;
        repeat (3) @(negedge clk);
        req = 1'b0;
        begin
            int dcount;
            dcount = 0;
            repeat (20) begin
                @(negedge clk);
                if (done) dcount++;
            end
            chk(dcount == 1, "R7 single done for busy request", dcount, 1);
        end
        chk(arr[5] == shadow[5], "R7 busy request not written", arr[5], shadow[5]);
        chk(arr[3] == 16'hBEEF, "R7 accepted write landed", arr[3], 16'hBEEF);
        shadow[3] = 16'hBEEF;
        xfer(1'b0, 18'h5, 16'h0, 2'b11, lat, turn);
        chk(rdata == shadow[5], "R7 readback of ignored address", rdata, shadow[5]);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule